// File: doc/BRIEF.md
# NAND Sequential Cache-Read Sequencer

This block is a controller-side sequencer that reads a run of physically consecutive pages from a raw NAND device. It drives the command-latch and address-latch strobes, the shared command/address byte and the read strobe, and it watches the device's ready/busy line. It returns the page contents as a byte stream tagged with the page number, with a pulse at the end of each page and at the end of the run.

When the capability input `seq_en` is high at start, the sequencer sends the full read setup only for the first page. After that it chains cache commands. Each cache command makes the device move the loaded page into its cache and begin loading the following page, so the array read overlaps with the host transfer. The final page gets the closing cache command. When `seq_en` is low, every page repeats the whole setup. A ready wait that runs too long aborts the run with an error flag.

Top module: `nand_seqread_ctrl`

## Requirements
- R1: After reset, `cle`, `ale`, `rd_stb`, `dout_valid`, `page_done`, `run_done`, `busy` and `timeout_err` are all low.
- R2: A run begins with a command cycle carrying 0x00, then five address cycles, then a command cycle carrying 0x30. The address cycles are two zero column bytes followed by the first page number, least significant byte first. `cle` and `ale` are never high together.
- R3: With `seq_en` high at start, the device is not sent 0x00 or 0x30 again after the first setup. Each page except the last is preceded by one command 0x31, and the last page is preceded by one command 0x3F.
- R4: A sequential run whose first and last page are equal sends 0x00, the address, 0x30 and then 0x3F, and never sends 0x31.
- R5: With `seq_en` low at start, each page gets its own 0x00, address (with that page's number) and 0x30 sequence. Neither 0x31 nor 0x3F is sent.
- R6: `rd_stb` is high only while `rb_n` is high. The first `rd_stb` of a page comes no sooner than RR_CYC+1 cycles after the first cycle in which `rb_n` is seen high again.
- R7: Each page yields PAGE_BYTES bytes. Each byte is valid one cycle after its `rd_stb` cycle and equals the `rd_data` present in that cycle. `dout_page` gives the page number, and pages come out in ascending order.
- R8: `page_done` is high together with the last byte of every page. `run_done` is high together with the last byte of the run. `busy` is high from the cycle after start until the run ends.
- R9: If `rb_n` stays low for more than `wait_limit` cycles of a ready wait, `timeout_err` rises, `busy` drops in the same cycle and no further strobes are issued. The next start clears `timeout_err`.
- R10: A start pulse while `busy` is high is ignored. The page numbers and `seq_en` are taken only at an accepted start.
- R11: If `last_page` is below `first_page` at start, the run covers only `first_page`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (taken when idle) |
| first_page | input | 24 | First page number of the run |
| last_page | input | 24 | Last page number of the run |
| seq_en | input | 1 | Use cache-sequential reads when high |
| wait_limit | input | 16 | Ready-wait timeout, in cycles |
| rb_n | input | 1 | Device ready (high) / busy (low) |
| rd_data | input | 8 | Byte from the device during read strobes |
| cle | output | 1 | Command latch strobe |
| ale | output | 1 | Address latch strobe |
| cmd_addr | output | 8 | Command or address byte |
| rd_stb | output | 1 | Read strobe, one byte per cycle |
| dout | output | 8 | Data byte out |
| dout_valid | output | 1 | `dout` is valid |
| dout_page | output | 24 | Page number of `dout` |
| page_done | output | 1 | Last byte of a page |
| run_done | output | 1 | Last byte of the run |
| busy | output | 1 | Run in progress |
| timeout_err | output | 1 | Last run aborted on a ready timeout |

## Verification
The bench uses a device model that keeps its own cache and pending-page registers. A sequencer that sent 0x31 before the last page instead of 0x3F, or that sent 0x31 on a single-page run, would be marked as wrong. It would also be caught if it repeated the setup in sequential mode or got the byte order of the row address wrong, because the logged command stream and the page tags on the data would differ from expectation. The directed cases are a one-page run, a 64-page run, a reversed page range, a start during a run with the page inputs changed, and a device stuck busy. A design that started strobing too early after ready, or latched inputs after start, would show up there, as would one that hung on a stuck device or left the error set on the next run.

// File: rtl/nsr_pkg.sv
package nsr_pkg;

    localparam int ROW_BYTES = 3;
    localparam int COL_BYTES = 2;
    localparam int ROW_W     = 8 * ROW_BYTES;
    localparam int ADDR_CYC  = ROW_BYTES + COL_BYTES;

    localparam logic [7:0] OP_SETUP      = 8'h00;
    localparam logic [7:0] OP_ARRAY_GO   = 8'h30;
    localparam logic [7:0] OP_CACHE_NEXT = 8'h31;
    localparam logic [7:0] OP_CACHE_LAST = 8'h3F;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SETUP, ST_ADDR, ST_GO, ST_WAIT, ST_CACHE, ST_XFER
    } seq_state_e;

    typedef enum logic [1:0] {
        WP_IDLE, WP_BLANK, WP_BUSY, WP_SETTLE
    } wait_phase_e;

    typedef struct packed {
        logic             valid;
        logic [7:0]       data;
        logic [ROW_W-1:0] page;
        logic             page_end;
        logic             run_end;
    } beat_t;

    // Byte sent in address cycle idx: zero columns, then row LSB first.
    function automatic logic [7:0] addr_byte(input logic [ROW_W-1:0] row,
                                             input logic [2:0] idx);
        logic [ROW_W-1:0] sh;
        if (idx < 3'(COL_BYTES)) return 8'h00;
        sh = row >> {idx - 3'(COL_BYTES), 3'b000};
        return sh[7:0];
    endfunction

    function automatic logic [ROW_W-1:0] final_page(input logic [ROW_W-1:0] first,
                                                     input logic [ROW_W-1:0] last);
        return (last < first) ? first : last;
    endfunction

endpackage

// File: rtl/nsr_ready_wait.sv
module nsr_ready_wait
    import nsr_pkg::*;
#(
    parameter int WB_CYC = 2,
    parameter int RR_CYC = 2,
    parameter int LIM_W  = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic             rb_n,
    input  logic [LIM_W-1:0] limit,
    output logic             done,
    output logic             tmo
);
    localparam logic [LIM_W-1:0] BLANK_END  = LIM_W'(WB_CYC - 1);
    localparam logic [LIM_W-1:0] SETTLE_END = LIM_W'(RR_CYC - 1);

    wait_phase_e      phase;
    logic [LIM_W-1:0] cnt;

    assign done = (phase == WP_SETTLE) && (cnt == SETTLE_END);
    assign tmo  = (phase == WP_BUSY) && !rb_n && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= WP_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                WP_IDLE: begin
                    cnt <= '0;
                    if (go) phase <= WP_BLANK;
                end
                WP_BLANK: begin
                    if (cnt == BLANK_END) begin
                        phase <= WP_BUSY;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                WP_BUSY: begin
                    if (rb_n) begin
                        phase <= WP_SETTLE;
                        cnt   <= '0;
                    end else if (tmo) begin
                        phase <= WP_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                WP_SETTLE: begin
                    if (done) begin
                        phase <= WP_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= WP_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nsr_data_pump.sv
module nsr_data_pump
    import nsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic [7:0]       rd_data,
    input  logic [ROW_W-1:0] page,
    input  logic             page_end,
    input  logic             run_end,
    output beat_t            beat
);
    always_ff @(posedge clk) begin
        if (rst) begin
            beat <= '0;
        end else begin
            beat.valid    <= cap;
            beat.page_end <= cap && page_end;
            beat.run_end  <= cap && run_end;
            if (cap) begin
                beat.data <= rd_data;
                beat.page <= page;
            end
        end
    end
endmodule

// File: rtl/nsr_seq_fsm.sv
module nsr_seq_fsm
    import nsr_pkg::*;
#(
    parameter int PAGE_BYTES = 2048
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [ROW_W-1:0] first_page,
    input  logic [ROW_W-1:0] last_page,
    input  logic             seq_en,
    input  logic             wait_done,
    input  logic             wait_tmo,
    output logic             wait_go,
    output logic             cle,
    output logic             ale,
    output logic [7:0]       cmd_addr,
    output logic             rd_stb,
    output logic [ROW_W-1:0] cur_page,
    output logic             page_end,
    output logic             run_end,
    output logic             busy,
    output logic             err
);
    localparam int               BYTE_W    = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
    localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(PAGE_BYTES - 1);
    localparam logic [2:0]        LAST_ADDR = 3'(ADDR_CYC - 1);

    seq_state_e        state;
    logic [ROW_W-1:0]  stop_page;
    logic              seq_mode;
    logic              to_cache;
    logic [2:0]        addr_idx;
    logic [BYTE_W-1:0] byte_cnt;
    logic              at_last;

    assign at_last  = (cur_page == stop_page);
    assign busy     = (state != ST_IDLE);
    assign cle      = (state == ST_SETUP) || (state == ST_GO) || (state == ST_CACHE);
    assign ale      = (state == ST_ADDR);
    assign rd_stb   = (state == ST_XFER);
    assign wait_go  = (state == ST_GO) || (state == ST_CACHE);
    assign page_end = rd_stb && (byte_cnt == LAST_BYTE);
    assign run_end  = page_end && at_last;

    always_comb begin
        unique case (state)
            ST_SETUP: cmd_addr = OP_SETUP;
            ST_ADDR:  cmd_addr = addr_byte(cur_page, addr_idx);
            ST_GO:    cmd_addr = OP_ARRAY_GO;
            ST_CACHE: cmd_addr = at_last ? OP_CACHE_LAST : OP_CACHE_NEXT;
            default:  cmd_addr = 8'h00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            stop_page <= '0;
            seq_mode  <= 1'b0;
            to_cache  <= 1'b0;
            addr_idx  <= '0;
            byte_cnt  <= '0;
            cur_page  <= '0;
            err       <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    cur_page  <= first_page;
                    stop_page <= final_page(first_page, last_page);
                    seq_mode  <= seq_en;
                    err       <= 1'b0;
                    state     <= ST_SETUP;
                end
                ST_SETUP: begin
                    addr_idx <= '0;
                    state    <= ST_ADDR;
                end
                ST_ADDR: begin
                    if (addr_idx == LAST_ADDR) state <= ST_GO;
                    else addr_idx <= addr_idx + 1'b1;
                end
                ST_GO: begin
                    to_cache <= seq_mode;
                    state    <= ST_WAIT;
                end
                ST_CACHE: begin
                    to_cache <= 1'b0;
                    state    <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (wait_tmo) begin
                        err   <= 1'b1;
                        state <= ST_IDLE;
                    end else if (wait_done) begin
                        byte_cnt <= '0;
                        state    <= to_cache ? ST_CACHE : ST_XFER;
                    end
                end
                ST_XFER: begin
                    byte_cnt <= byte_cnt + 1'b1;
                    if (page_end) begin
                        if (at_last) begin
                            state <= ST_IDLE;
                        end else begin
                            cur_page <= cur_page + 1'b1;
                            state    <= seq_mode ? ST_CACHE : ST_SETUP;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/nand_seqread_ctrl.sv
module nand_seqread_ctrl
    import nsr_pkg::*;
#(
    parameter int PAGE_BYTES = 2048,
    parameter int WB_CYC     = 2,
    parameter int RR_CYC     = 2,
    parameter int LIM_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [ROW_W-1:0] first_page,
    input  logic [ROW_W-1:0] last_page,
    input  logic             seq_en,
    input  logic [LIM_W-1:0] wait_limit,
    input  logic             rb_n,
    input  logic [7:0]       rd_data,
    output logic             cle,
    output logic             ale,
    output logic [7:0]       cmd_addr,
    output logic             rd_stb,
    output logic [7:0]       dout,
    output logic             dout_valid,
    output logic [ROW_W-1:0] dout_page,
    output logic             page_done,
    output logic             run_done,
    output logic             busy,
    output logic             timeout_err
);
    logic             wait_go, wait_done, wait_tmo;
    logic [ROW_W-1:0] cur_page;
    logic             page_end, run_end;
    beat_t            beat;

    nsr_seq_fsm #(.PAGE_BYTES(PAGE_BYTES)) u_fsm (
        .clk(clk), .rst(rst), .start(start),
        .first_page(first_page), .last_page(last_page), .seq_en(seq_en),
        .wait_done(wait_done), .wait_tmo(wait_tmo), .wait_go(wait_go),
        .cle(cle), .ale(ale), .cmd_addr(cmd_addr), .rd_stb(rd_stb),
        .cur_page(cur_page), .page_end(page_end), .run_end(run_end),
        .busy(busy), .err(timeout_err)
    );

    nsr_ready_wait #(.WB_CYC(WB_CYC), .RR_CYC(RR_CYC), .LIM_W(LIM_W)) u_wait (
        .clk(clk), .rst(rst), .go(wait_go), .rb_n(rb_n), .limit(wait_limit),
        .done(wait_done), .tmo(wait_tmo)
    );

    nsr_data_pump u_pump (
        .clk(clk), .rst(rst), .cap(rd_stb), .rd_data(rd_data),
        .page(cur_page), .page_end(page_end), .run_end(run_end), .beat(beat)
    );

    assign dout       = beat.data;
    assign dout_valid = beat.valid;
    assign dout_page  = beat.page;
    assign page_done  = beat.page_end;
    assign run_done   = beat.run_end;
endmodule

// File: rtl/nsr_checker.sv
module nsr_checker #(
    parameter int RR_CYC = 2
) (
    input logic clk,
    input logic rst,
    input logic rb_n,
    input logic cle,
    input logic ale,
    input logic rd_stb,
    input logic dout_valid,
    input logic page_done,
    input logic run_done,
    input logic busy,
    input logic timeout_err
);
    logic [7:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !rb_n) hi_cnt <= '0;
        else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 1'b1;
    end

    // R2
    cle_ale_excl_chk: assert property (@(posedge clk) disable iff (rst) !(cle && ale));
    // R6
    rd_ready_chk: assert property (@(posedge clk) disable iff (rst) rd_stb |-> rb_n);
    // R6
    rd_settle_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && !$past(rd_stb)) |-> (hi_cnt >= 8'(RR_CYC)));
    // R7
    valid_after_rd_chk: assert property (@(posedge clk) disable iff (rst) dout_valid |-> $past(rd_stb));
    // R8
    page_done_valid_chk: assert property (@(posedge clk) disable iff (rst) page_done |-> dout_valid);
    // R8
    run_done_page_chk: assert property (@(posedge clk) disable iff (rst) run_done |-> page_done);
    // R9
    tmo_idle_chk: assert property (@(posedge clk) disable iff (rst) $rose(timeout_err) |-> !busy);
    // R8
    strobe_busy_chk: assert property (@(posedge clk) disable iff (rst) (cle || ale || rd_stb) |-> busy);
endmodule

bind nand_seqread_ctrl nsr_checker #(.RR_CYC(RR_CYC)) u_nsr_checker (
    .clk(clk), .rst(rst), .rb_n(rb_n), .cle(cle), .ale(ale), .rd_stb(rd_stb),
    .dout_valid(dout_valid), .page_done(page_done), .run_done(run_done),
    .busy(busy), .timeout_err(timeout_err)
);

// File: tb/tb_nand_seqread_ctrl.sv
module tb_nand_seqread_ctrl;
    localparam int PB = 16;
    localparam int RR = 3;
    localparam int WB = 2;

    logic        clk = 0, rst = 1, start = 0, seq_en = 0, rb_n;
    logic [23:0] first_page = 0, last_page = 0, dout_page;
    logic [15:0] wait_limit = 16'd1000;
    logic [7:0]  rd_data, cmd_addr, dout;
    logic        cle, ale, rd_stb, dout_valid, page_done, run_done, busy, timeout_err;

    always #2 clk = ~clk;

    nand_seqread_ctrl #(.PAGE_BYTES(PB), .WB_CYC(WB), .RR_CYC(RR)) dut (.*);

    int checks = 0, fails = 0, cycles = 0;

    // ---------------- device model ----------------
    logic [23:0] row_acc = 0, cache_pg = 0, pend_pg = 0;
    int          bsy = 0, idx = 0, an = 0;
    logic        stuck = 0;
    logic [8:0]  dlog [0:1023];
    int          ln = 0;
    logic        log_clr = 0;

    function automatic logic [7:0] pat(input logic [23:0] p, input int i);
        return (p[7:0] * 8'd31) ^ 8'(i) ^ p[15:8] ^ p[23:16];
    endfunction

    assign rb_n    = (bsy == 0) && !stuck;
    assign rd_data = pat(cache_pg, idx);

    always @(posedge clk) begin
        if (bsy > 0) bsy <= bsy - 1;
        if (log_clr) ln <= 0;
        else if (cle || ale) begin
            dlog[ln] <= {ale, cmd_addr};
            ln <= ln + 1;
        end
        if (rd_stb) idx <= idx + 1;
        if (cle) begin
            idx <= 0;
            case (cmd_addr)
                8'h00: an <= 0;
                8'h30: begin cache_pg <= row_acc; pend_pg <= row_acc; bsy <= 10 + int'($urandom % 10); end
                8'h31: begin cache_pg <= pend_pg; pend_pg <= pend_pg + 1; bsy <= 3 + int'($urandom % 4); end
                8'h3F: begin cache_pg <= pend_pg; bsy <= 3 + int'($urandom % 4); end
                default: ;
            endcase
        end
        if (ale) begin
            if (an >= 2) row_acc[8*(an-2) +: 8] <= cmd_addr;
            an <= an + 1;
        end
    end

    // ---------------- output and timing monitors ----------------
    logic [23:0] exp_pg = 0, exp_stop = 0;
    int          exp_i = 0, pages_seen = 0, runs_seen = 0, hi = 0;
    logic        prev_rd = 0;

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (!rst && rd_stb && !prev_rd) begin
            checks++;
            if (!rb_n || hi < RR + 1) begin
                fails++;
                $display("FAIL R6: read strobe after %0d ready cycles, rb_n=%0b, expected >= %0d and 1", hi, rb_n, RR + 1);
            end
        end
        prev_rd <= rd_stb;
        hi <= rb_n ? hi + 1 : 0;
        if (!rst && dout_valid) begin
            checks++;
            if (dout !== pat(exp_pg, exp_i) || dout_page !== exp_pg ||
                page_done !== (exp_i == PB - 1) ||
                run_done !== (exp_i == PB - 1 && exp_pg == exp_stop)) begin
                fails++;
                $display("FAIL R7/R8: byte %0d page %h got d=%h pg=%h pd=%0b rd=%0b expected d=%h pd=%0b",
                         exp_i, exp_pg, dout, dout_page, page_done, run_done,
                         pat(exp_pg, exp_i), exp_i == PB - 1);
            end
            if (exp_i == PB - 1) begin
                pages_seen <= pages_seen + 1;
                if (run_done) runs_seen <= runs_seen + 1;
                exp_i  <= 0;
                exp_pg <= exp_pg + 1;
            end else begin
                exp_i <= exp_i + 1;
            end
        end
    end

    // ---------------- bench helpers ----------------
    logic [8:0] elog [0:1023];
    int         en;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input bit a, input logic [7:0] b);
        elog[en] = {a, b};
        en++;
    endtask

    task automatic push_setup(input logic [23:0] r);
        push(0, 8'h00); push(1, 8'h00); push(1, 8'h00);
        push(1, r[7:0]); push(1, r[15:8]); push(1, r[23:16]);
        push(0, 8'h30);
    endtask

    task automatic build_exp(input logic [23:0] f, input logic [23:0] l, input bit s);
        logic [23:0] stop = (l < f) ? f : l;
        en = 0;
        if (s) begin
            push_setup(f);
            for (logic [23:0] p = f; p <= stop; p++) push(0, (p == stop) ? 8'h3F : 8'h31);
        end else begin
            for (logic [23:0] p = f; p <= stop; p++) push_setup(p);
        end
    endtask

    task automatic pulse_start(input logic [23:0] f, input logic [23:0] l, input bit s);
        @(negedge clk);
        first_page = f; last_page = l; seq_en = s; start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 20000) begin @(negedge clk); n++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic run_case(input logic [23:0] f, input logic [23:0] l, input bit s,
                            input bit mid, input string req);
        int bad = 0, first_bad = -1;
        logic [23:0] stop = (l < f) ? f : l;
        @(negedge clk);
        log_clr = 1;
        @(negedge clk);
        log_clr = 0;
        build_exp(f, l, s);
        exp_pg = f; exp_i = 0; exp_stop = stop; pages_seen = 0; runs_seen = 0;
        pulse_start(f, l, s);
        chk(busy === 1'b1, {req, " busy after start (R8)"}, busy, 1);
        chk(timeout_err === 1'b0, "R9 error cleared by start", timeout_err, 0);
        if (mid) begin
            repeat (12) @(negedge clk);
            first_page = f + 24'd100; last_page = f + 24'd103; seq_en = !s; start = 1;
            @(negedge clk);
            start = 0;
        end
        wait_idle();
        for (int i = 0; i < en; i++) if (i >= ln || dlog[i] !== elog[i]) begin
            bad++;
            if (first_bad < 0) first_bad = i;
        end
        chk(bad == 0 && ln == en, {req, " command/address stream"}, ln, en);
        if (first_bad >= 0)
            $display("      first mismatch at %0d: got %h expected %h", first_bad, dlog[first_bad], elog[first_bad]);
        chk(pages_seen == int'(stop - f) + 1, {req, " pages delivered (R7)"}, pages_seen, int'(stop - f) + 1);
        chk(runs_seen == 1, {req, " one run_done (R8)"}, runs_seen, 1);
        chk(busy === 1'b0, {req, " idle at end (R8)"}, busy, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        wait (cycles >= 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'h0000_5EED));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk({cle, ale, rd_stb, dout_valid, page_done, run_done, busy, timeout_err} === 8'h00,
            "R1 outputs idle after reset", {cle, ale, rd_stb, dout_valid, page_done, run_done, busy, timeout_err}, 0);

        // R2 R3 sequential with distinct row bytes, LSB first
        run_case(24'hA1B2C3, 24'hA1B2C6, 1, 0, "R2 R3 seq run");
        // R4 single page sequential
        run_case(24'h00_1234, 24'h00_1234, 1, 0, "R4 single page");
        // R5 normal mode, per-page setup
        run_case(24'h3C_00FE, 24'h3C_0101, 0, 0, "R5 normal run");
        // R11 reversed range
        run_case(24'h00_0050, 24'h00_0010, 1, 0, "R11 reversed seq");
        run_case(24'h00_0090, 24'h00_0001, 0, 0, "R11 reversed normal");
        // R10 start ignored while busy, inputs changed mid-run
        run_case(24'h12_3400, 24'h12_3402, 1, 1, "R10 seq restart ignored");
        run_case(24'h45_6700, 24'h45_6701, 0, 1, "R10 normal restart ignored");
        // whole erase block of 64 pages
        run_case(24'h00_0040, 24'h00_007F, 1, 0, "R3 64-page block");

        // random runs
        for (int k = 0; k < 10; k++) begin
            logic [23:0] f = 24'($urandom) & 24'hFFFF00;
            logic [23:0] l = f + 24'($urandom % 6);
            run_case(f, l, 1'($urandom % 2), 0, "R3 R5 R7 random run");
        end

        // R9 ready timeout: device stuck busy
        wait_limit = 16'd40;
        stuck = 1;
        @(negedge clk);
        log_clr = 1;
        @(negedge clk);
        log_clr = 0;
        pulse_start(24'h00_0005, 24'h00_0007, 1);
        repeat (20) @(negedge clk);
        chk(timeout_err === 1'b0 && busy === 1'b1, "R9 still waiting before limit", timeout_err, 0);
        repeat (60) @(negedge clk);
        chk(timeout_err === 1'b1, "R9 timeout flag set", timeout_err, 1);
        chk(busy === 1'b0, "R9 idle after timeout", busy, 0);
        chk(ln == 7, "R9 no strobes after timeout", ln, 7);
        repeat (30) @(negedge clk);
        chk(ln == 7 && !rd_stb, "R9 still quiet later", ln, 7);
        stuck = 0;
        repeat (5) @(negedge clk);
        wait_limit = 16'd1000;
        run_case(24'h00_0200, 24'h00_0202, 1, 0, "R9 recovery run");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule